// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one burst to a double-data-rate memory. A burst begins on a start strobe, which carries a starting column, a burst length code and an ordering select. From the clock edge that captures the strobe, the block presents one column address per cycle, with a valid flag. It raises a last flag on the final address of the burst.

Only the low bits that fall inside the burst take part in the ordering: one bit for a two-beat burst, two bits for four beats and three bits for eight. All column bits above that field stay unchanged for the whole burst. The ordering is either a count that wraps inside the aligned block or an XOR of the start offset with the beat index. A new start interrupts a burst in progress. A start that carries a reserved length code is ignored.

A parameter sets how far each output cycle advances. In single mode every beat gets its own cycle. In paired mode each cycle covers two beats and shows the address of the even beat of the pair.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o and last_o are low until a start with a legal length code is accepted.
- R2: When start_i is high with a legal code at a rising edge, the first address appears on the next cycle with valid_o high, and it equals start_col_i.
- R3: Length code 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. The block shows one address per beat in single mode and one per beat pair in paired mode.
- R4: With interleave_i low, the low field of beat k is (start offset + k) modulo the burst length, so the sequence wraps inside its aligned block.
- R5: With interleave_i high, the low field of beat k is the start offset XOR k.
- R6: Column bits above the burst field equal those of start_col_i on every beat.
- R7: With a zero start offset, both orderings give the same ascending sequence.
- R8: last_o is high only on the final address of a burst. On the cycle after it, valid_o is low unless a new legal start was accepted.
- R9: A legal start during a burst abandons the old burst. The next cycle shows beat 0 of the new burst.
- R10: A start with code 3'b000 or any code with bit 2 set has no effect: an ongoing burst continues unchanged and an idle block stays idle.
- R11: A legal start that arrives on the cycle the last beat is shown makes the new burst follow with no idle cycle.
- R12: With PAIR_MODE set to 1, the shown beats are 0, 2, 4 and 6 of the ordering, so an 8-beat burst takes 4 cycles and a 2-beat burst takes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W | Starting column address |
| bl_code_i | input | 3 | Burst length code (001=2, 010=4, 011=8, others reserved) |
| interleave_i | input | 1 | 0 selects wrapping sequential order, 1 selects XOR order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat address |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
Beat 0 of a burst is due one clock after the edge that captures the strobe. Each later beat comes one cycle after the one before it. The drop of valid_o is due one cycle after last_o. The bench drives its inputs at the falling edge. At each rising edge it updates a queue-based model, which it reloads on a legal start and pops otherwise. It then compares the head of the queue with the outputs at the next falling edge, so every result is sampled in the cycle it is due. A single-mode instance and a paired-mode instance both run on the same stimulus.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Width of the reordered field for the largest burst (8 beats)
   localparam int OFS_W = 3;

   // Burst length codes: the decoder depends on these values
   localparam logic [2:0] BLC_TWO   = 3'b001;
   localparam logic [2:0] BLC_FOUR  = 3'b010;
   localparam logic [2:0] BLC_EIGHT = 3'b011;

   typedef logic [OFS_W-1:0] ofs_t;

   typedef struct packed {
      logic ok;      // code is legal
      ofs_t mask;    // bits that take part in the ordering
      ofs_t last;    // beat index of the final shown beat
   } len_info_t;

endpackage

// File: rtl/bsq_len_decode.sv
module bsq_len_decode
   import burst_seq_pkg::*;
#(
   parameter int PAIR_MODE = 0
) (
   input  logic [2:0] code_i,
   output len_info_t  info_o
);

   localparam ofs_t STEP_V = (PAIR_MODE != 0) ? ofs_t'(2) : ofs_t'(1);

   always_comb begin
      info_o = '0;
      unique case (code_i)
         BLC_TWO: begin
            info_o.ok   = 1'b1;
            info_o.mask = 3'b001;
            info_o.last = ofs_t'(2) - STEP_V;
         end
         BLC_FOUR: begin
            info_o.ok   = 1'b1;
            info_o.mask = 3'b011;
            info_o.last = ofs_t'(4) - STEP_V;
         end
         BLC_EIGHT: begin
            info_o.ok   = 1'b1;
            info_o.mask = 3'b111;
            info_o.last = ofs_t'(8) - STEP_V;
         end
         default: info_o = '0;
      endcase
   end

endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
   import burst_seq_pkg::*;
#(
   parameter int PAIR_MODE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  ofs_t last_i,
   output logic active_o,
   output ofs_t idx_o,
   output logic at_last_o
);

   localparam ofs_t STEP_V = (PAIR_MODE != 0) ? ofs_t'(2) : ofs_t'(1);

   ofs_t last_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         idx_o    <= '0;
         last_r   <= '0;
      end else if (load_i) begin
         active_o <= 1'b1;
         idx_o    <= '0;
         last_r   <= last_i;
      end else if (active_o) begin
         if (idx_o == last_r) begin
            active_o <= 1'b0;
         end else begin
            idx_o <= idx_o + STEP_V;
         end
      end
   end

   assign at_last_o = active_o && (idx_o == last_r);

   // R3
   idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (idx_o <= last_r));

endmodule

// File: rtl/bsq_addr_map.sv
module bsq_addr_map
   import burst_seq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] base_i,
   input  ofs_t             mask_i,
   input  logic             xor_mode_i,
   input  ofs_t             idx_i,
   output logic [COL_W-1:0] col_o
);

   ofs_t seq_low;
   ofs_t xor_low;
   ofs_t pick;

   assign seq_low = base_i[OFS_W-1:0] + idx_i;
   assign xor_low = base_i[OFS_W-1:0] ^ idx_i;
   assign pick    = xor_mode_i ? xor_low : seq_low;

   for (genvar b = 0; b < OFS_W; b++) begin : g_low
      assign col_o[b] = mask_i[b] ? pick[b] : base_i[b];
   end

   if (COL_W > OFS_W) begin : g_high
      assign col_o[COL_W-1:OFS_W] = base_i[COL_W-1:OFS_W];
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int PAIR_MODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             interleave_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   if (COL_W < OFS_W) begin : g_bad_width
      $error("burst_col_seq: COL_W must be at least 3");
   end
   if (PAIR_MODE != 0 && PAIR_MODE != 1) begin : g_bad_mode
      $error("burst_col_seq: PAIR_MODE must be 0 or 1");
   end

   len_info_t        info;
   logic             start_ok;
   logic [COL_W-1:0] base_r;
   ofs_t             mask_r;
   logic             xor_r;
   ofs_t             beat_idx;

   bsq_len_decode #(.PAIR_MODE(PAIR_MODE)) u_dec (
      .code_i (bl_code_i),
      .info_o (info)
   );

   assign start_ok = start_i && info.ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_r <= '0;
         mask_r <= '0;
         xor_r  <= 1'b0;
      end else if (start_ok) begin
         base_r <= start_col_i;
         mask_r <= info.mask;
         xor_r  <= interleave_i;
      end
   end

   bsq_beat_ctr #(.PAIR_MODE(PAIR_MODE)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_ok),
      .last_i    (info.last),
      .active_o  (valid_o),
      .idx_o     (beat_idx),
      .at_last_o (last_o)
   );

   bsq_addr_map #(.COL_W(COL_W)) u_map (
      .base_i     (base_r),
      .mask_i     (mask_r),
      .xor_mode_i (xor_r),
      .idx_i      (beat_idx),
      .col_o      (col_o)
   );

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (valid_o && col_o == $past(start_col_i)));

   // R8
   last_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R8
   drop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_ok) |=> !valid_o);

   if (COL_W > OFS_W) begin : g_hi_chk
      // R6
      upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_o && $past(valid_o) && !$past(start_ok))
            |-> (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W])));
   end

endmodule

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       bl_code_i = 3'b000;
   logic             interleave_i = 1'b0;
   logic [COL_W-1:0] col_a, col_b;
   logic             val_a, val_b, last_a, last_b;

   int n_checks = 0;
   int n_fails  = 0;
   int qa[$];
   int qb[$];

   always #4 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .PAIR_MODE(0)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .bl_code_i(bl_code_i), .interleave_i(interleave_i),
      .col_o(col_a), .valid_o(val_a), .last_o(last_a));

   burst_col_seq #(.COL_W(COL_W), .PAIR_MODE(1)) dut_pair (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .bl_code_i(bl_code_i), .interleave_i(interleave_i),
      .col_o(col_b), .valid_o(val_b), .last_o(last_b));

   function automatic int exp_col(int start, int bl, bit ilv, int k);
      int ofs = start % bl;
      int low = ilv ? (ofs ^ k) : ((ofs + k) % bl);
      return start - ofs + low;
   endfunction

   task automatic model_edge(bit s, int col, int code, bit ilv);
      if (s && code >= 1 && code <= 3) begin
         int bl = 1 << code;
         qa.delete();
         qb.delete();
         for (int k = 0; k < bl; k++) qa.push_back(exp_col(col, bl, ilv, k));
         for (int k = 0; k < bl; k += 2) qb.push_back(exp_col(col, bl, ilv, k));
      end else begin
         if (qa.size() > 0) void'(qa.pop_front());
         if (qb.size() > 0) void'(qb.pop_front());
      end
   endtask

   task automatic compare(string tag, string which, logic v, logic [COL_W-1:0] c,
                          logic l, int q[$]);
      bit ev = (q.size() > 0);
      bit el = (q.size() == 1);
      int ec = ev ? q[0] : 0;
      bit bad = (v !== ev) || (l !== el) || (ev && (c !== ec[COL_W-1:0]));
      n_checks++;
      if (bad) begin
         n_fails++;
         $display("FAIL %s %s: valid=%0b col=%0h last=%0b expected valid=%0b col=%0h last=%0b",
                  tag, which, v, c, l, ev, ec, el);
      end
   endtask

   task automatic cyc(bit s, int col, int code, bit ilv, string tag);
      start_i      = s;
      start_col_i  = col[COL_W-1:0];
      bl_code_i    = code[2:0];
      interleave_i = ilv;
      @(posedge clk);
      model_edge(s, col, code, ilv);
      @(negedge clk);
      compare(tag, "single", val_a, col_a, last_a, qa);
      compare({tag, "/R12"}, "paired", val_b, col_b, last_b, qb);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 8);
      n_fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fails, n_checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs idle after reset
      n_checks++;
      if (val_a !== 1'b0 || last_a !== 1'b0 || val_b !== 1'b0 || last_b !== 1'b0) begin
         n_fails++;
         $display("FAIL R1: valid=%0b last=%0b expected valid=0 last=0", val_a, last_a);
      end
      idle(2, "R1");
      // R4 sequential wrap, start offset 5, BL8 (R2 first beat)
      cyc(1'b1, 'h125, 3, 1'b0, "R2");
      idle(9, "R4");
      // R5 interleave, start offset 3, BL8
      cyc(1'b1, 'h2A3, 3, 1'b1, "R5");
      idle(9, "R5");
      // R3/R6 BL4 sequential, offset 2, upper bits kept
      cyc(1'b1, 'h3E6, 2, 1'b0, "R3");
      idle(5, "R6");
      // R3 BL2 interleave, odd start
      cyc(1'b1, 'h0B7, 1, 1'b1, "R3");
      idle(3, "R3");
      // R7 zero offset in both modes
      cyc(1'b1, 'h1F8, 3, 1'b1, "R7");
      idle(9, "R7");
      cyc(1'b1, 'h1F8, 3, 1'b0, "R7");
      idle(9, "R7");
      // R9 interrupt mid-burst
      cyc(1'b1, 'h044, 3, 1'b0, "R9");
      idle(2, "R9");
      cyc(1'b1, 'h10D, 2, 1'b1, "R9");
      idle(5, "R9");
      // R10 reserved codes during a burst and while idle
      cyc(1'b1, 'h061, 3, 1'b0, "R10");
      cyc(1'b1, 'h3FF, 0, 1'b1, "R10");
      cyc(1'b1, 'h3FF, 4, 1'b0, "R10");
      cyc(1'b1, 'h3FF, 7, 1'b1, "R10");
      idle(6, "R10");
      cyc(1'b1, 'h155, 5, 1'b0, "R10");
      idle(2, "R10");
      // R11 back-to-back at the last beat, R8 drop afterwards
      cyc(1'b1, 'h0F2, 2, 1'b0, "R11");
      idle(3, "R11");
      cyc(1'b1, 'h0F1, 2, 1'b1, "R11");
      idle(5, "R8");
      // R12 paired mode boundary: BL2 is a single cycle
      cyc(1'b1, 'h201, 1, 1'b0, "R12");
      idle(3, "R12");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule